// File: doc/BRIEF.md
# Clocked Weighted Threshold Gate

This block evaluates a single programmable threshold function over up to eight binary inputs. Each input carries its own signed integer weight. Inputs whose weight is positive add their weight to a "load" sum. Inputs whose weight is negative add the magnitude of their weight to an opposing "driver" sum, and the threshold also acts on the driver side. The output resolves to 1 when the load side exceeds the driver side plus the threshold, and to 0 otherwise.

The threshold always sits halfway between two neighbouring integers. It is given as a pair of bounds, upper and lower, so the pair 2 and 1 stands for 1.5, and the comparison can never tie. With unit weights the same element covers AND, OR, inhibit (A AND NOT B) and implication (A OR NOT B). With graded weights it covers nested AND/OR chains in one step.

Evaluation runs in two phases. A start strobe freezes the inputs, weights and bounds into the block. One clock later the output is resolved and latched, and a one-cycle done pulse marks it. The result then holds until the next evaluation.

Top module: `thg_gate`

## Requirements
- R1: After synchronous reset, q, done and cfg_err are all 0.
- R2: Weight of input i sits in weights[5i+4:5i] as 5-bit two's complement (-16..15), and input i adds its weight to the sum only when in_bits[i] is 1. The bounds thr_hi and thr_lo are 6-bit two's complement.
- R3: Positive weights add to the load sum and negative weights add their magnitude to the driver sum. The extremes do not overflow: all eight weights at 15, or all eight at -16, still give the correct result.
- R4: With thr_hi = thr_lo + 1, q is 1 exactly when 2*(load - driver) > thr_hi + thr_lo. This means the signed weighted sum exceeds thr_lo + 0.5. A tie cannot occur.
- R5: With inputs A = in_bits[0] and B = in_bits[1], and all other weights 0, the following functions result. Weights (1,1) with bounds 2:1 give AND. Weights (1,1) with 1:0 give OR. Weights (1,-1) with 1:0 give A AND NOT B. Weights (1,-1) with 0:-1 give A OR NOT B.
- R6: Inputs A..F are in_bits[0..5] with weights 8,5,3,2,1,1, and the bounds are 8:7. This gives A OR (B AND (C OR (D AND (E OR F)))).
- R7: start high at a rising edge while idle captures all inputs at that edge. q and cfg_err update at the next rising edge, and done is high for exactly the one cycle after that edge.
- R8: Changes to in_bits, weights or bounds after the capture edge do not affect the result. A start that is high during the evaluate cycle is ignored.
- R9: Between evaluations q and cfg_err hold their values whatever the inputs do.
- R10: If thr_hi - thr_lo is not 1 at capture, the evaluation sets cfg_err = 1 and forces q = 0. The next valid evaluation clears cfg_err.
- R11: No two-input setting of weights and adjacent bounds gives XOR or XNOR of A and B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_bits | input | 8 | Binary inputs |
| weights | input | 40 | Packed signed weights, 5 bits per input |
| thr_hi | input | 6 | Upper threshold bound, signed |
| thr_lo | input | 6 | Lower threshold bound, signed |
| start | input | 1 | Capture and evaluate strobe |
| q | output | 1 | Latched threshold result |
| done | output | 1 | One-cycle pulse when q is new |
| cfg_err | output | 1 | Last evaluation had non-adjacent bounds |

## Verification
The bench sweeps every input pattern against preset gates and against a mixed-sign weight set with full-scale entries. A design that dropped the sign when splitting terms, or summed at too narrow a width, would report wrong values near the extremes. It perturbs inputs and re-asserts start during the evaluate cycle. A design that read live inputs there would latch the perturbed answer, and one that accepted the second strobe would pulse done twice. It also sweeps a grid of two-input weights and bounds and shows that none of them produces XOR or XNOR. It supplies non-adjacent bounds and checks that q is forced low, so a design that compared against a rounded threshold would be caught.

// File: rtl/thg_pkg.sv
// Package: shared sizes and the phase type of the threshold gate.
// Assumes weights fit in W_WT-bit two's complement, so a magnitude fits in
// W_WT unsigned bits, and that eight or fewer inputs keep sums small.
package thg_pkg;
    parameter int unsigned N_IN  = 8;
    parameter int unsigned W_WT  = 5;
    parameter int unsigned W_THR = 6;

    localparam int unsigned MAG_W = W_WT;
    localparam int unsigned SUM_W = MAG_W + $clog2(N_IN);
    localparam int unsigned CMP_W = SUM_W + W_THR;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EVAL = 1'b1
    } phase_t;
endpackage

// File: rtl/thg_term.sv
// Module: one weighted input term.
// Routes the weight of an active input to the load side (non-negative
// weight) or its magnitude to the driver side (negative weight).
// Assumes W_WT-bit two's complement; -2^(W_WT-1) maps to magnitude 2^(W_WT-1).
module thg_term #(
    parameter int unsigned W_WT = 5
) (
    input  logic                   bit_in,
    input  logic [W_WT-1:0]        wt,
    output logic [W_WT-1:0]        load_mag,
    output logic [W_WT-1:0]        drv_mag
);
    logic neg;

    // Split the term by the sign of its weight.
    always_comb begin
        neg      = wt[W_WT-1];
        load_mag = (bit_in && !neg) ? wt : '0;
        drv_mag  = (bit_in && neg) ? (~wt + 1'b1) : '0;
    end
endmodule

// File: rtl/thg_adder.sv
// Module: unsigned sum of N magnitudes.
// Assumes SUM_W holds N * 2^(MAG_W-1) without wrap.
module thg_adder #(
    parameter int unsigned N     = 8,
    parameter int unsigned MAG_W = 5,
    parameter int unsigned SUM_W = 8
) (
    input  logic [N*MAG_W-1:0] mags,
    output logic [SUM_W-1:0]   sum
);
    // Accumulate every magnitude at full sum width.
    always_comb begin
        sum = '0;
        for (int i = 0; i < N; i++) begin
            sum = sum + SUM_W'(mags[i*MAG_W +: MAG_W]);
        end
    end
endmodule

// File: rtl/thg_compare.sv
// Module: half-step threshold comparator.
// Computes margin = 2*load - 2*driver - (hi + lo) and fires when it is
// positive. Flags the bound pair as bad when hi - lo is not exactly one.
// Assumes CMP_W exceeds both SUM_W + 2 and W_THR + 1.
module thg_compare #(
    parameter int unsigned SUM_W = 8,
    parameter int unsigned W_THR = 6,
    parameter int unsigned CMP_W = 14
) (
    input  logic [SUM_W-1:0]         load_sum,
    input  logic [SUM_W-1:0]         drv_sum,
    input  logic [W_THR-1:0]         hi,
    input  logic [W_THR-1:0]         lo,
    output logic signed [CMP_W-1:0]  margin,
    output logic                     fire,
    output logic                     cfg_bad
);
    logic signed [CMP_W-1:0] load_s;
    logic signed [CMP_W-1:0] drv_s;
    logic signed [CMP_W-1:0] hi_s;
    logic signed [CMP_W-1:0] lo_s;
    logic signed [W_THR:0]   gap;

    // Widen operands with the right extension.
    always_comb begin
        load_s = $signed({{(CMP_W-SUM_W){1'b0}}, load_sum});
        drv_s  = $signed({{(CMP_W-SUM_W){1'b0}}, drv_sum});
        hi_s   = $signed({{(CMP_W-W_THR){hi[W_THR-1]}}, hi});
        lo_s   = $signed({{(CMP_W-W_THR){lo[W_THR-1]}}, lo});
    end

    // Doubled comparison avoids the half step.
    always_comb begin
        margin = (load_s <<< 1) - (drv_s <<< 1) - (hi_s + lo_s);
        fire   = (margin > 0);
    end

    // Bound pair must be adjacent integers.
    always_comb begin
        gap     = $signed({hi[W_THR-1], hi}) - $signed({lo[W_THR-1], lo});
        cfg_bad = (gap != (W_THR+1)'(1));
    end
endmodule

// File: rtl/thg_gate.sv
// Module: clocked weighted threshold gate (top).
// A start strobe in idle captures inputs, weights and bounds. The following
// cycle evaluates the captured copy, latches q and cfg_err and pulses done.
// Results hold until the next evaluation. Synchronous active-low reset.
module thg_gate
    import thg_pkg::*;
#(
    parameter int unsigned P_N_IN  = N_IN,
    parameter int unsigned P_W_WT  = W_WT,
    parameter int unsigned P_W_THR = W_THR
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [P_N_IN-1:0]          in_bits,
    input  logic [P_N_IN*P_W_WT-1:0]   weights,
    input  logic [P_W_THR-1:0]         thr_hi,
    input  logic [P_W_THR-1:0]         thr_lo,
    input  logic                       start,
    output logic                       q,
    output logic                       done,
    output logic                       cfg_err
);
    localparam int unsigned L_SUM_W = P_W_WT + $clog2(P_N_IN);
    localparam int unsigned L_CMP_W = L_SUM_W + P_W_THR;

    phase_t                       phase;
    logic [P_N_IN-1:0]            cap_bits;
    logic [P_N_IN*P_W_WT-1:0]     cap_wts;
    logic [P_W_THR-1:0]           cap_hi;
    logic [P_W_THR-1:0]           cap_lo;
    logic [P_N_IN*P_W_WT-1:0]     load_mags;
    logic [P_N_IN*P_W_WT-1:0]     drv_mags;
    logic [L_SUM_W-1:0]           load_sum;
    logic [L_SUM_W-1:0]           drv_sum;
    logic signed [L_CMP_W-1:0]    margin;
    logic                         fire;
    logic                         cfg_bad;
    logic                         accept;

    assign accept = (phase == PH_IDLE) && start;

    // Phase sequencer: idle, then a single evaluate cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (accept) begin
            phase <= PH_EVAL;
        end else begin
            phase <= PH_IDLE;
        end
    end

    // Capture inputs on an accepted strobe; frozen otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_bits <= '0;
            cap_wts  <= '0;
            cap_hi   <= '0;
            cap_lo   <= '0;
        end else if (accept) begin
            cap_bits <= in_bits;
            cap_wts  <= weights;
            cap_hi   <= thr_hi;
            cap_lo   <= thr_lo;
        end
    end

    // Per-input term splitters.
    for (genvar gi = 0; gi < P_N_IN; gi++) begin : g_term
        thg_term #(.W_WT(P_W_WT)) u_term (
            .bit_in   (cap_bits[gi]),
            .wt       (cap_wts[gi*P_W_WT +: P_W_WT]),
            .load_mag (load_mags[gi*P_W_WT +: P_W_WT]),
            .drv_mag  (drv_mags[gi*P_W_WT +: P_W_WT])
        );
    end

    thg_adder #(.N(P_N_IN), .MAG_W(P_W_WT), .SUM_W(L_SUM_W)) u_load_add (
        .mags (load_mags),
        .sum  (load_sum)
    );

    thg_adder #(.N(P_N_IN), .MAG_W(P_W_WT), .SUM_W(L_SUM_W)) u_drv_add (
        .mags (drv_mags),
        .sum  (drv_sum)
    );

    thg_compare #(.SUM_W(L_SUM_W), .W_THR(P_W_THR), .CMP_W(L_CMP_W)) u_cmp (
        .load_sum (load_sum),
        .drv_sum  (drv_sum),
        .hi       (cap_hi),
        .lo       (cap_lo),
        .margin   (margin),
        .fire     (fire),
        .cfg_bad  (cfg_bad)
    );

    // Latch the resolved state at the end of the evaluate cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= 1'b0;
            done    <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            done <= (phase == PH_EVAL);
            if (phase == PH_EVAL) begin
                cfg_err <= cfg_bad;
                q       <= fire && !cfg_bad;
            end
        end
    end

    // R7: done lasts exactly one cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done only follows an evaluate cycle.
    p_done_after_eval_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(phase == PH_EVAL));

    // R8: captured operands stay frozen through evaluation.
    p_capture_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EVAL) |=> ($stable(cap_bits) && $stable(cap_wts)
                                && $stable(cap_hi) && $stable(cap_lo)));

    // R9: results change only together with done.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(q) && $stable(cfg_err)));

    // R10: a bad bound pair never yields a high output.
    p_cfg_forces_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !q);

    // R4: adjacent bounds make a tie impossible.
    p_no_tie_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_EVAL) && !cfg_bad) |-> (margin != 0));
endmodule

// File: tb/tb_thg_gate.sv
module tb_thg_gate;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_bits = '0;
    logic [39:0] weights = '0;
    logic [5:0]  thr_hi = '0;
    logic [5:0]  thr_lo = '0;
    logic        start = 1'b0;
    logic        q;
    logic        done;
    logic        cfg_err;

    int checks = 0;
    int errors = 0;
    int wt_i[8];
    int hi_i;
    int lo_i;

    thg_gate dut (
        .clk(clk), .rst_n(rst_n), .in_bits(in_bits), .weights(weights),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .start(start),
        .q(q), .done(done), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_cfg();
        for (int i = 0; i < 8; i++) weights[i*5 +: 5] = 5'(wt_i[i]);
        thr_hi = 6'(hi_i);
        thr_lo = 6'(lo_i);
    endtask

    function automatic int ref_q(input logic [7:0] b);
        int s = 0;
        for (int i = 0; i < 8; i++) if (b[i]) s += wt_i[i];
        if (hi_i - lo_i != 1) return 0;
        return (2*s > hi_i + lo_i) ? 1 : 0;
    endfunction

    function automatic void clear_wts();
        for (int i = 0; i < 8; i++) wt_i[i] = 0;
    endfunction

    // Drive config and bits, strobe, return at the negedge where q is new.
    // perturb: scramble operands after capture and keep start high one more cycle.
    task automatic eval(input logic [7:0] b, input bit perturb);
        @(negedge clk);
        load_cfg();
        in_bits = b;
        start = 1'b1;
        @(negedge clk);
        if (perturb) begin
            in_bits = ~b;
            weights = ~weights;
            thr_hi = thr_hi + 6'd5;
        end else begin
            start = 1'b0;
        end
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int found;
        logic [3:0] pat;
        logic a, b2, c, d, e, f;
        logic qhold;

        repeat (3) @(negedge clk);
        // R1: reset state
        check(q == 0, "R1 q after reset", q, 0);
        check(done == 0, "R1 done after reset", done, 0);
        check(cfg_err == 0, "R1 cfg_err after reset", cfg_err, 0);
        rst_n = 1'b1;

        // R5: unit-weight presets over all A,B patterns
        for (int g = 0; g < 4; g++) begin
            clear_wts();
            wt_i[0] = 1;
            wt_i[1] = (g >= 2) ? -1 : 1;
            hi_i = (g == 0) ? 2 : (g == 3) ? 0 : 1;
            lo_i = hi_i - 1;
            for (int p = 0; p < 4; p++) begin
                int exp;
                a = p[0]; b2 = p[1];
                case (g)
                    0: exp = a & b2;
                    1: exp = a | b2;
                    2: exp = a & ~b2;
                    default: exp = a | ~b2;
                endcase
                eval(8'(p), 1'b0);
                check(q == exp[0], $sformatf("R5 gate%0d AB=%0d", g, p), q, exp);
                check(done == 1, "R7 done after eval", done, 1);
                @(negedge clk);
                check(done == 0, "R7 done one cycle", done, 0);
            end
        end

        // R6: graded-weight nested function, all 64 patterns
        clear_wts();
        wt_i[0] = 8; wt_i[1] = 5; wt_i[2] = 3; wt_i[3] = 2; wt_i[4] = 1; wt_i[5] = 1;
        hi_i = 8; lo_i = 7;
        for (int p = 0; p < 64; p++) begin
            int exp;
            {f, e, d, c, b2, a} = 6'(p);
            exp = a | (b2 & (c | (d & (e | f))));
            eval(8'(p), 1'b0);
            check(q == exp[0], $sformatf("R6 pattern=%0d", p), q, exp);
        end

        // R2/R3/R4: mixed signs with full-scale weights, all 256 patterns
        wt_i = '{15, -16, 7, -1, 15, -16, 3, -5};
        for (int t = 0; t < 3; t++) begin
            hi_i = (t == 0) ? 1 : (t == 1) ? -20 : 25;
            lo_i = hi_i - 1;
            for (int p = 0; p < 256; p++) begin
                eval(8'(p), 1'b0);
                check(q == ref_q(8'(p)), $sformatf("R4 thr%0d pattern=%0d", t, p), q, ref_q(8'(p)));
            end
        end

        // R3: extremes, no overflow
        for (int i = 0; i < 8; i++) wt_i[i] = 15;
        hi_i = 31; lo_i = 30;
        eval(8'hFF, 1'b0);
        check(q == 1, "R3 all +15 vs 30.5", q, 1);
        for (int i = 0; i < 8; i++) wt_i[i] = -16;
        hi_i = -31; lo_i = -32;
        eval(8'hFF, 1'b0);
        check(q == 0, "R3 all -16 vs -31.5", q, 0);
        eval(8'h00, 1'b0);
        check(q == 1, "R2 no active inputs vs -31.5", q, 1);

        // R8: perturbation after capture and a second strobe are ignored
        clear_wts();
        wt_i[0] = 1; wt_i[1] = 1; hi_i = 2; lo_i = 1;
        eval(8'h03, 1'b1);
        check(q == 1, "R8 AND with late changes", q, 1);
        check(done == 1, "R8 done after eval", done, 1);
        @(negedge clk);
        check(done == 0, "R8 second strobe ignored", done, 0);
        eval(8'h01, 1'b1);
        check(q == 0, "R8 AND 01 with late changes", q, 0);

        // R9: hold with moving inputs and no strobe
        qhold = q;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_bits = 8'(k * 37);
            weights = {8{5'(k)}};
            check(q == qhold && done == 0, "R9 q holds", q, qhold);
        end

        // R10: non-adjacent bounds force q low and set cfg_err
        clear_wts();
        wt_i[0] = 5; hi_i = 3; lo_i = 1;
        eval(8'h01, 1'b0);
        check(cfg_err == 1, "R10 cfg_err set", cfg_err, 1);
        check(q == 0, "R10 q forced low", q, 0);
        hi_i = 2; lo_i = 2;
        eval(8'h01, 1'b0);
        check(cfg_err == 1, "R10 equal bounds flagged", cfg_err, 1);
        hi_i = 2; lo_i = 1;
        eval(8'h01, 1'b0);
        check(cfg_err == 0, "R10 cfg_err cleared", cfg_err, 0);
        check(q == 1, "R10 valid eval result", q, 1);

        // R11: no two-input setting yields XOR or XNOR
        found = 0;
        clear_wts();
        for (int w0 = -3; w0 <= 3; w0++) begin
            for (int w1 = -3; w1 <= 3; w1++) begin
                for (int l = -7; l <= 6; l++) begin
                    wt_i[0] = w0; wt_i[1] = w1; lo_i = l; hi_i = l + 1;
                    for (int p = 0; p < 4; p++) begin
                        eval(8'(p), 1'b0);
                        pat[p] = q;
                        check(q == ref_q(8'(p)), "R11 sweep point", q, ref_q(8'(p)));
                    end
                    if (pat == 4'b0110 || pat == 4'b1001) found++;
                end
            end
        end
        check(found == 0, "R11 XOR/XNOR settings found", found, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule